// File: doc/BRIEF.md
# Dual-Sample Serial Output Framer

This block sends two converter results per symbol period to a signal processor over one serial data line. It runs on the 48x oversampling clock and launches every bit on that clock's falling edge, so the receiver can take each bit on the following rising edge. A symbol strobe marks the symbol period. The falling edge of the strobe, as seen on a falling clock edge, starts a new 48-bit frame.

Each frame carries two 16-bit words. The first word holds the main conversion of the symbol period and the second holds an independent conversion taken in the middle of the same period. Each word is followed by eight filler bits that are held high. Inside a word the 14-bit two's complement sample sits in the upper bits and two low pad bits are zero. Both samples are copied into a holding register when the frame starts. If a slot received no new sample since the previous frame start, its last value is sent again and that slot's miss flag is raised for the whole frame.

Top module: `dual_sample_framer`

## Requirements
- R1: After reset `ser_out` is 1 and `miss_a` and `miss_b` are 0. `ser_out` stays 1 until the first frame start, even while `sym_strobe` is held low.
- R2: A frame starts on the falling clock edge at which `sym_strobe` is sampled 0, provided it was sampled 1 on the previous falling edge. On that same edge `ser_out` carries bit 15 of the first word.
- R3: Frame bit order, counted 1 to 48 from the frame start: bits 1-16 are the first word, MSB first; bits 17-24 are 1; bits 25-40 are the second word, MSB first; bits 41-48 are 1.
- R4: Word bit positions: the 14-bit sample occupies bits 15:2 of its word, and bits 1:0 are 0.
- R5: Samples go out unchanged as two's complement. Positive full scale 0x1FFF, mid scale 0x0000 and negative full scale 0x2000 keep their codes.
- R6: Samples are held from the frame start. A valid sample that arrives during a frame does not change that frame, and it is sent in the next frame.
- R7: A change on a sample data input while its valid input is 0 has no effect on any frame.
- R8: If a slot receives no valid sample between two frame starts, its previous value is sent again. That slot's miss flag is 1 from the new frame start until the next frame start. The other slot's flag is unaffected.
- R9: If no new frame start occurs after bit 48, `ser_out` returns to 1 and stays there.
- R10: A valid sample present on the same clock edge as the frame start is used in the frame that starts on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48x bit clock; all logic acts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sym_strobe | input | 1 | Symbol-period strobe; a high-to-low change starts a frame |
| samp_a_data | input | 14 | Main conversion result, two's complement |
| samp_a_valid | input | 1 | Qualifies `samp_a_data` for one clock |
| samp_b_data | input | 14 | Mid-period conversion result, two's complement |
| samp_b_valid | input | 1 | Qualifies `samp_b_data` for one clock |
| ser_out | output | 1 | Serial frame data, MSB first |
| miss_a | output | 1 | First slot repeated its previous value in the current frame |
| miss_b | output | 1 | Second slot repeated its previous value in the current frame |

## Verification
The hardest case to reach from the ports is a valid sample that coincides exactly with the frame-start edge while the same slot has nothing pending. Only the coincident sample then decides between a fresh value and a repeat with the miss flag set. The bench creates this case by raising the second slot's valid in the same half cycle as it lowers the strobe, after a frame in which only the first slot was fed. It then expects the new value in bits 25-40 and a low `miss_b`. A frame in which the first slot's data toggles without valid and its valid never arrives covers the repeat path and the isolation of each slot's flag.

// File: rtl/dual_sample_framer_pkg.sv
package dual_sample_framer_pkg;
  localparam int DEF_SAMPLE_W = 14;
  localparam int DEF_PAD_W    = 2;
  localparam int DEF_FILL_W   = 8;
  localparam int NUM_SLOTS    = 2;

  typedef enum logic [2:0] {
    SEG_IDLE,
    SEG_WORD_A,
    SEG_FILL_A,
    SEG_WORD_B,
    SEG_FILL_B
  } seg_e;
endpackage

// File: rtl/framer_reset_sync.sv
module framer_reset_sync (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(negedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/frame_slot_counter.sv
module frame_slot_counter #(
  parameter int FRAME_LEN = 48,
  parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_in,
  output logic             frame_start,
  output logic [CNT_W-1:0] slot_q,
  output logic [CNT_W-1:0] slot_nx
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic strobe_q;

  assign frame_start = strobe_q & ~strobe_in;

  always_comb begin
    if (frame_start)                        slot_nx = ONE;
    else if (slot_q == '0 || slot_q == LAST) slot_nx = '0;
    else                                    slot_nx = slot_q + ONE;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      slot_q   <= '0;
    end else begin
      strobe_q <= strobe_in;
      slot_q   <= slot_nx;
    end
  end

  assert_start_slot_R2: assert property (@(negedge clk) disable iff (!rst_n)
    frame_start |=> (slot_q == ONE));
  assert_slot_range_R3: assert property (@(negedge clk) disable iff (!rst_n)
    slot_q <= LAST);
  assert_park_idle_R9: assert property (@(negedge clk) disable iff (!rst_n)
    (slot_q == LAST && !frame_start) |=> (slot_q == '0));
endmodule

// File: rtl/sample_slot.sv
module sample_slot #(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                in_valid,
  output logic [SAMPLE_W-1:0] hold_nx,
  output logic                miss
);
  logic [SAMPLE_W-1:0] pend_q, pend_nx, hold_q;
  logic                pend_f_q, pend_f_nx, miss_nx;

  always_comb begin
    pend_nx   = in_valid ? in_data : pend_q;
    pend_f_nx = take ? 1'b0 : (pend_f_q | in_valid);
    hold_nx   = take ? pend_nx : hold_q;
    miss_nx   = take ? ~(in_valid | pend_f_q) : miss;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      pend_f_q <= 1'b0;
      hold_q   <= '0;
      miss     <= 1'b0;
    end else begin
      pend_q   <= pend_nx;
      pend_f_q <= pend_f_nx;
      hold_q   <= hold_nx;
      miss     <= miss_nx;
    end
  end

  assert_hold_stable_R6: assert property (@(negedge clk) disable iff (!rst_n)
    !take |=> $stable(hold_q));
  assert_repeat_miss_R8: assert property (@(negedge clk) disable iff (!rst_n)
    (take && !in_valid && !pend_f_q) |=> (miss && $stable(hold_q)));
  assert_coincident_R10: assert property (@(negedge clk) disable iff (!rst_n)
    (take && in_valid) |=> (!miss && hold_q == $past(in_data)));
endmodule

// File: rtl/frame_bit_mux.sv
module frame_bit_mux
  import dual_sample_framer_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int PAD_W    = 2,
  parameter int FILL_W   = 8,
  parameter int CNT_W    = 6
) (
  input  logic [CNT_W-1:0]    slot,
  input  logic [SAMPLE_W-1:0] word_a,
  input  logic [SAMPLE_W-1:0] word_b,
  output seg_e                seg,
  output logic                bit_o
);
  localparam int WORD_W = SAMPLE_W + PAD_W;
  localparam int HALF_W = WORD_W + FILL_W;

  int                pos;
  logic [WORD_W-1:0] word, shifted;

  always_comb begin
    pos   = int'(slot) - 1;
    word  = {word_a, {PAD_W{1'b0}}};
    seg   = SEG_IDLE;
    if (slot == '0) begin
      seg = SEG_IDLE;
    end else if (pos < WORD_W) begin
      seg = SEG_WORD_A;
    end else if (pos < HALF_W) begin
      seg = SEG_FILL_A;
    end else if (pos < HALF_W + WORD_W) begin
      seg  = SEG_WORD_B;
      word = {word_b, {PAD_W{1'b0}}};
      pos  = pos - HALF_W;
    end else begin
      seg = SEG_FILL_B;
    end
    shifted = word << pos;
    bit_o   = (seg == SEG_WORD_A || seg == SEG_WORD_B) ? shifted[WORD_W-1] : 1'b1;
  end
endmodule

// File: rtl/dual_sample_framer.sv
module dual_sample_framer
  import dual_sample_framer_pkg::*;
#(
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int PAD_W    = DEF_PAD_W,
  parameter int FILL_W   = DEF_FILL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sym_strobe,
  input  logic [SAMPLE_W-1:0] samp_a_data,
  input  logic                samp_a_valid,
  input  logic [SAMPLE_W-1:0] samp_b_data,
  input  logic                samp_b_valid,
  output logic                ser_out,
  output logic                miss_a,
  output logic                miss_b
);
  localparam int WORD_W    = SAMPLE_W + PAD_W;
  localparam int HALF_W    = WORD_W + FILL_W;
  localparam int FRAME_LEN = NUM_SLOTS * HALF_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic                rst_i_n;
  logic                frame_start;
  logic [CNT_W-1:0]    slot_q, slot_nx;
  logic [SAMPLE_W-1:0] in_data [NUM_SLOTS];
  logic                in_valid [NUM_SLOTS];
  logic [SAMPLE_W-1:0] hold_nx [NUM_SLOTS];
  logic                miss [NUM_SLOTS];
  logic                ser_nx;
  seg_e                seg_nx;
  int                  slot_i;

  assign in_data[0]  = samp_a_data;
  assign in_data[1]  = samp_b_data;
  assign in_valid[0] = samp_a_valid;
  assign in_valid[1] = samp_b_valid;
  assign miss_a      = miss[0];
  assign miss_b      = miss[1];

  framer_reset_sync u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_i_n)
  );

  frame_slot_counter #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .strobe_in   (sym_strobe),
    .frame_start (frame_start),
    .slot_q      (slot_q),
    .slot_nx     (slot_nx)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    sample_slot #(.SAMPLE_W(SAMPLE_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .take     (frame_start),
      .in_data  (in_data[g]),
      .in_valid (in_valid[g]),
      .hold_nx  (hold_nx[g]),
      .miss     (miss[g])
    );
  end

  frame_bit_mux #(.SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W), .FILL_W(FILL_W), .CNT_W(CNT_W)) u_mux (
    .slot   (slot_nx),
    .word_a (hold_nx[0]),
    .word_b (hold_nx[1]),
    .seg    (seg_nx),
    .bit_o  (ser_nx)
  );

  always_ff @(negedge clk or negedge rst_i_n) begin
    if (!rst_i_n) ser_out <= 1'b1;
    else          ser_out <= ser_nx;
  end

  assign slot_i = int'(slot_q);

  assert_idle_high_R1: assert property (@(negedge clk) disable iff (!rst_i_n)
    (slot_i == 0) |-> ser_out);
  assert_pad_low_R4: assert property (@(negedge clk) disable iff (!rst_i_n)
    ((slot_i > WORD_W - PAD_W && slot_i <= WORD_W) ||
     (slot_i > HALF_W + WORD_W - PAD_W && slot_i <= HALF_W + WORD_W)) |-> !ser_out);
  assert_filler_high_R3: assert property (@(negedge clk) disable iff (!rst_i_n)
    ((slot_i > WORD_W && slot_i <= HALF_W) || slot_i > HALF_W + WORD_W) |-> ser_out);
endmodule

// File: tb/dual_sample_framer_tb.sv
module dual_sample_framer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sym_strobe;
  logic [13:0] a_data, b_data;
  logic        a_valid, b_valid;
  logic        ser_out, miss_a, miss_b;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_sample_framer dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sym_strobe   (sym_strobe),
    .samp_a_data  (a_data),
    .samp_a_valid (a_valid),
    .samp_b_data  (b_data),
    .samp_b_valid (b_valid),
    .ser_out      (ser_out),
    .miss_a       (miss_a),
    .miss_b       (miss_b)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load(input bit sel_b, input logic [13:0] d);
    if (sel_b) begin b_data = d; b_valid = 1'b1; end
    else       begin a_data = d; a_valid = 1'b1; end
    step();
    a_valid = 1'b0; b_valid = 1'b0;
  endtask

  // One frame, started by dropping the strobe now; optionally feeds the next
  // frame mid-way, glitches A data without valid, or gives B at the start edge.
  task automatic run_frame(input string req, input logic [13:0] ea, input logic [13:0] eb,
                           input bit ema, input bit emb,
                           input bit na_v, input logic [13:0] na,
                           input bit nb_v, input logic [13:0] nb,
                           input bit gl_v, input logic [13:0] gl,
                           input bit cb_v, input logic [13:0] cb);
    logic [47:0] got, exp;
    sym_strobe = 1'b0;
    if (cb_v) begin b_data = cb; b_valid = 1'b1; end
    for (int i = 0; i < 48; i++) begin
      step();
      got[47-i] = ser_out;
      if (i == 0) b_valid = 1'b0;
      if (i == 5) begin
        check(miss_a == ema, req, "miss_a", 64'(miss_a), 64'(ema));
        check(miss_b == emb, req, "miss_b", 64'(miss_b), 64'(emb));
      end
      if (i == 10 && gl_v) a_data = gl;
      if (i == 20) sym_strobe = 1'b1;
      if (i == 30 && na_v) begin a_data = na; a_valid = 1'b1; end
      if (i == 31) a_valid = 1'b0;
      if (i == 33 && nb_v) begin b_data = nb; b_valid = 1'b1; end
      if (i == 34) b_valid = 1'b0;
    end
    exp = {ea, 2'b00, 8'hFF, eb, 2'b00, 8'hFF};
    check(got == exp, req, "frame bits", 64'(got), 64'(exp));
  endtask

  task automatic test_reset_idle();
    rst_n = 1'b0; sym_strobe = 1'b0;
    a_data = '0; b_data = '0; a_valid = 1'b0; b_valid = 1'b0;
    repeat (3) step();
    check(ser_out == 1'b1, "R1", "ser_out in reset", 64'(ser_out), 64'd1);
    check(!miss_a && !miss_b, "R1", "miss flags in reset", {62'd0, miss_a, miss_b}, 64'd0);
    rst_n = 1'b1;
    begin
      bit stayed = 1'b1;
      for (int i = 0; i < 12; i++) begin step(); if (ser_out !== 1'b1) stayed = 1'b0; end
      check(stayed, "R1", "idle high with strobe low", 64'(stayed), 64'd1);
    end
    sym_strobe = 1'b1;
    step();
  endtask

  task automatic test_full_scale_frame();
    load(1'b0, 14'h1FFF);
    load(1'b1, 14'h2000);
    step();
    // R2 R3 R4 R5: full-scale codes in place; feeds next frame during this one (R6)
    run_frame("R2/R3/R4/R5", 14'h1FFF, 14'h2000, 1'b0, 1'b0,
              1'b1, 14'h0000, 1'b1, 14'h1234, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic test_next_frame_and_glitch();
    // R6: values given mid-frame appear now; A data glitches without valid (R7)
    run_frame("R6/R5", 14'h0000, 14'h1234, 1'b0, 1'b0,
              1'b0, '0, 1'b1, 14'h0F0F, 1'b1, 14'h2AAA, 1'b0, '0);
  endtask

  task automatic test_underrun_a();
    // R8 R7: A repeats and flags, B fresh; next A fed, B only at the start edge
    run_frame("R8/R7", 14'h0000, 14'h0F0F, 1'b1, 1'b0,
              1'b1, 14'h3FFF, 1'b0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic test_coincident_b();
    // R10: B valid on the start edge is used now; R8 flag clears for A
    run_frame("R10/R8", 14'h3FFF, 14'h1555, 1'b0, 1'b0,
              1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 14'h1555);
  endtask

  task automatic test_idle_after_frame();
    bit stayed = 1'b1;
    for (int i = 0; i < 20; i++) begin step(); if (ser_out !== 1'b1) stayed = 1'b0; end
    check(stayed, "R9", "idle high after bit 48", 64'(stayed), 64'd1);
  endtask

  initial begin
    test_reset_idle();
    test_full_scale_frame();
    test_next_frame_and_glitch();
    test_underrun_a();
    test_coincident_b();
    test_idle_after_frame();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule